// File: doc/BRIEF.md
# Scan-Line Pause Timer for Sound Command Channels

This block times the PAUSE command of a sound engine that fetches its commands by DMA. All channels share one prescaler. It counts scan-line strobes and gives one tick after every N+1 strobes. N is an 8-bit value that software writes.

Each channel has a 12-bit pause counter. A PAUSE command loads this counter. The counter steps down once on each shared tick while its channel is enabled. The block raises a per-channel `paused` flag, and the command fetcher holds that channel's fetch while the flag is high.

A channel moves through three named states:
- `CH_IDLE`: not paused.
- `CH_RUN`: paused and counting.
- `CH_FROZEN`: paused with its count held because the channel is disabled.

The transitions are:
- **load-nonzero**: any state goes to `CH_RUN` if enabled, or to `CH_FROZEN` if disabled.
- **load-zero**: any state goes to `CH_IDLE`.
- **disable**: `CH_RUN` goes to `CH_FROZEN`.
- **enable**: `CH_FROZEN` goes to `CH_RUN`.
- **expire**: `CH_RUN` or `CH_FROZEN` goes to `CH_IDLE` when the last tick arrives while the channel is enabled.

The prescaler is a free-running counter. It wraps when it reaches the programmed value, and a write to the prescale register restarts it from zero.

Top module: `snd_pause_timer`

## Requirements
- R1: After reset, all `paused` bits are 0, and the prescale value and prescaler phase are 0.
- R2: With prescale value N (0..255), one tick occurs on every (N+1)-th `line_stb` pulse, counted from reset or from the last prescale write.
- R3: A `pause_ld` pulse with a nonzero value M sets that channel's `paused` bit from the next cycle on. While enabled, the bit clears in the cycle after the M-th tick. With a fresh prescaler phase, this is after M*(N+1) line strobes.
- R4: A `pause_ld` pulse with value 0 leaves or puts the channel in the not-paused state from the next cycle on, and cancels any pause in progress.
- R5: While `ch_en` of a paused channel is 0, its count holds and `paused` stays 1. After `ch_en` returns to 1, counting resumes from the held value.
- R6: A `pre_wr` pulse loads `pre_val` and restarts the prescaler phase, so the new spacing applies to the remaining ticks at once. Example: PAUSE 10 at N=0, five line strobes, then N set to 1. The pause then ends after ten more strobes, fifteen in total.
- R7: An `addr_wr` pulse on a channel has no effect on its count or its `paused` bit.
- R8: A `pause_ld` pulse on a channel that is already paused restarts that channel's count with the new value. If a tick falls in the same cycle, the load takes precedence.
- R9: Channels count independently from the one shared tick. A load, disable or expiry on one channel does not change the `paused` bit of any other channel.
- R10: A `line_stb` pulse in the same cycle as `pre_wr` produces no tick and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per scan line |
| pre_wr | input | 1 | Prescale register write strobe |
| pre_val | input | 8 | Prescale value N |
| ch_en | input | 3 | Per-channel enable |
| pause_ld | input | 3 | Per-channel PAUSE load strobe |
| pause_val | input | 36 | Per-channel pause count; channel i is in bits [12i+11:12i] |
| addr_wr | input | 3 | Per-channel address register write strobe |
| paused | output | 3 | Per-channel paused flag; fetch is held while it is 1 |

## Verification
Two events can fall in the same cycle: a channel's load or disable, and the shared tick that would otherwise decrement that channel. A prescale write can also coincide with a line strobe. These collisions are provoked both directly, with PAUSE or disable issued on the very strobe that completes a prescaler period, and with long random runs that mix frequent strobes with rare loads, enables and prescale writes. Each cycle, the `paused` vector is compared with a bench model built from the requirements. Directed runs count the line strobes up to expiry and compare them with M*(N+1) or with the 15-line mixed-prescale figure.

// File: rtl/snd_pause_pkg.sv
package snd_pause_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_RUN    = 2'd1,
        CH_FROZEN = 2'd2
    } ch_state_e;

endpackage

// File: rtl/snd_pause_prescale.sv
module snd_pause_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             wr_stb,
    input  logic [PRE_W-1:0] wr_val,
    output logic             tick,
    output logic [PRE_W-1:0] phase_o,
    output logic [PRE_W-1:0] limit_o
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit_q;
    logic             wrap;

    // A strobe that meets the programmed limit ends the period.
    assign wrap = line_stb && !wr_stb && (phase_q == limit_q);
    assign tick = wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            limit_q <= '0;
        end else if (wr_stb) begin
            phase_q <= '0;
            limit_q <= wr_val;
        end else if (line_stb) begin
            if (wrap) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign limit_o = limit_q;

endmodule

// File: rtl/snd_pause_chan.sv
module snd_pause_chan
    import snd_pause_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic             paused,
    output logic [CNT_W-1:0] cnt_o
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ld_nz;
    logic             step;
    logic             last;

    assign ld_nz = (ld_val != '0);
    assign step  = en && tick;
    assign last  = (cnt_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ld) begin
                    cnt_d   = ld_val;
                    state_d = !ld_nz ? CH_IDLE : (en ? CH_RUN : CH_FROZEN);
                end
            end
            CH_RUN: begin
                if (ld) begin
                    cnt_d   = ld_val;
                    state_d = !ld_nz ? CH_IDLE : (en ? CH_RUN : CH_FROZEN);
                end else if (!en) begin
                    state_d = CH_FROZEN;
                end else if (step) begin
                    cnt_d   = cnt_q - 1'b1;
                    state_d = last ? CH_IDLE : CH_RUN;
                end
            end
            CH_FROZEN: begin
                if (ld) begin
                    cnt_d   = ld_val;
                    state_d = !ld_nz ? CH_IDLE : (en ? CH_RUN : CH_FROZEN);
                end else if (step) begin
                    cnt_d   = cnt_q - 1'b1;
                    state_d = last ? CH_IDLE : CH_RUN;
                end else if (en) begin
                    state_d = CH_RUN;
                end
            end
            default: begin
                state_d = CH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        paused = (state_q != CH_IDLE);
        cnt_o  = cnt_q;
    end

endmodule

// File: rtl/snd_pause_timer.sv
module snd_pause_timer #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_stb,
    input  logic                    pre_wr,
    input  logic [PRE_W-1:0]        pre_val,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       pause_ld,
    input  logic [NUM_CH*CNT_W-1:0] pause_val,
    input  logic [NUM_CH-1:0]       addr_wr,
    output logic [NUM_CH-1:0]       paused
);

    logic                         tick;
    logic [PRE_W-1:0]             pre_phase;
    logic [PRE_W-1:0]             pre_limit;
    logic [NUM_CH-1:0][CNT_W-1:0] chan_cnt;

    snd_pause_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_stb(line_stb),
        .wr_stb  (pre_wr),
        .wr_val  (pre_val),
        .tick    (tick),
        .phase_o (pre_phase),
        .limit_o (pre_limit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        snd_pause_chan #(.CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ch_en[g]),
            .tick  (tick),
            .ld    (pause_ld[g]),
            .ld_val(pause_val[g*CNT_W +: CNT_W]),
            .paused(paused[g]),
            .cnt_o (chan_cnt[g])
        );
    end

endmodule

module snd_pause_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         pre_wr,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0]            pause_ld,
    input logic [NUM_CH*CNT_W-1:0]      pause_val,
    input logic [NUM_CH-1:0]            addr_wr,
    input logic [NUM_CH-1:0]            paused,
    input logic                         tick,
    input logic [PRE_W-1:0]             pre_phase,
    input logic [PRE_W-1:0]             pre_limit,
    input logic [NUM_CH-1:0][CNT_W-1:0] chan_cnt
);

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wr |=> (pre_phase == '0)); // R6

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_phase <= pre_limit); // R2

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_LOAD_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
            (pause_ld[i] && pause_val[i*CNT_W +: CNT_W] != '0) |=> paused[i]); // R3

        AST_ZERO_NOPAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (pause_ld[i] && pause_val[i*CNT_W +: CNT_W] == '0) |=> !paused[i]); // R4

        AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (paused[i] && !ch_en[i] && !pause_ld[i]) |=> ($stable(chan_cnt[i]) && paused[i])); // R5

        AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(paused[i]) |-> $past((tick && ch_en[i]) || pause_ld[i])); // R3

        AST_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_wr[i] && !tick && !pause_ld[i]) |=> $stable(chan_cnt[i])); // R7
    end

endmodule

bind snd_pause_timer snd_pause_timer_chk #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_wr   (pre_wr),
    .ch_en    (ch_en),
    .pause_ld (pause_ld),
    .pause_val(pause_val),
    .addr_wr  (addr_wr),
    .paused   (paused),
    .tick     (tick),
    .pre_phase(pre_phase),
    .pre_limit(pre_limit),
    .chan_cnt (chan_cnt)
);

// File: tb/snd_pause_timer_test.sv
module snd_pause_timer_test;

    localparam int CLK_P  = 10;
    localparam int NCH    = 3;
    localparam int CW     = 12;
    localparam int PW     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_stb = 1'b0;
    logic              pre_wr = 1'b0;
    logic [PW-1:0]     pre_val = '0;
    logic [NCH-1:0]    ch_en = '1;
    logic [NCH-1:0]    pause_ld = '0;
    logic [NCH*CW-1:0] pause_val = '0;
    logic [NCH-1:0]    addr_wr = '0;
    logic [NCH-1:0]    paused;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model state
    int       m_phase = 0;
    int       m_lim   = 0;
    int       m_cnt [NCH];
    bit [NCH-1:0] m_p = '0;

    always #(CLK_P/2) clk = ~clk;

    snd_pause_timer uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .pre_wr(pre_wr),
        .pre_val(pre_val), .ch_en(ch_en), .pause_ld(pause_ld),
        .pause_val(pause_val), .addr_wr(addr_wr), .paused(paused)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // one clock: advance the model from the requirements, then compare
    task automatic step(input string tag);
        bit tk;
        tk = line_stb && !pre_wr && (m_phase == m_lim);                 // R2 R10
        for (int c = 0; c < NCH; c++) begin
            if (pause_ld[c]) begin                                        // R8
                m_cnt[c] = int'(pause_val[c*CW +: CW]);
                m_p[c]   = (m_cnt[c] != 0);                               // R4
            end else if (m_p[c] && ch_en[c] && tk) begin                  // R3 R5
                m_cnt[c]--;
                if (m_cnt[c] == 0) m_p[c] = 1'b0;
            end
        end
        if (pre_wr) begin m_phase = 0; m_lim = int'(pre_val); end         // R6
        else if (line_stb) m_phase = tk ? 0 : m_phase + 1;
        @(posedge clk);
        #1;
        line_stb = 1'b0; pre_wr = 1'b0; pause_ld = '0; addr_wr = '0;
        check(tag, 32'(paused), 32'(m_p));
    endtask

    task automatic set_pre(input int n);
        pre_val = PW'(n); pre_wr = 1'b1; step("R6 prescale write");
    endtask

    task automatic load(input int c, input int v);
        pause_ld[c] = 1'b1; pause_val[c*CW +: CW] = CW'(v); step("R3 load");
    endtask

    // strobe every cycle until channel c clears; return strobe count
    task automatic run_clear(input int c, output int n);
        n = 0;
        while (paused[c] && n < 5000) begin
            line_stb = 1'b1; step("R3 countdown"); n++;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        check("R1 reset paused", 32'(paused), 32'd0);
        step("R1 idle");

        // R2: N=3, PAUSE 1 -> 4 strobes
        set_pre(3); load(0, 1);
        check("R3 paused after load", 32'(paused[0]), 32'd1);
        run_clear(0, n); check("R2 tick spacing N=3", n, 4);

        // R3: N=2, PAUSE 4 -> 12 strobes
        set_pre(2); load(1, 4);
        run_clear(1, n); check("R3 M*(N+1)", n, 12);

        // R4: PAUSE 0 never pauses, and cancels a pause
        load(2, 0); check("R4 zero no pause", 32'(paused[2]), 32'd0);
        load(2, 7); load(2, 0); check("R4 zero cancels", 32'(paused[2]), 32'd0);

        // R6: example with 15 lines
        set_pre(0); load(0, 10);
        repeat (5) begin line_stb = 1'b1; step("R6 first half"); end
        set_pre(1);
        run_clear(0, n); check("R6 mixed prescale total", n + 5, 15);

        // R5: freeze while disabled
        set_pre(0); load(1, 3);
        line_stb = 1'b1; step("R5 one tick");
        ch_en[1] = 1'b0;
        repeat (20) begin line_stb = 1'b1; step("R5 frozen"); end
        check("R5 still paused", 32'(paused[1]), 32'd1);
        ch_en[1] = 1'b1;
        run_clear(1, n); check("R5 resume remaining", n, 2);

        // R7: address writes during a pause
        set_pre(1); load(2, 3);
        n = 0;
        while (paused[2] && n < 100) begin
            line_stb = 1'b1; addr_wr[2] = 1'b1; step("R7 addr write"); n++;
        end
        check("R7 addr write no effect", n, 6);

        // R8: reload on a tick cycle wins; R9 other channel unaffected
        set_pre(0); load(0, 2); load(1, 5);
        line_stb = 1'b1; pause_ld[0] = 1'b1; pause_val[0 +: CW] = CW'(4);
        step("R8 load beats tick");
        run_clear(0, n); check("R8 reload count", n, 4);
        check("R9 other channel kept", 32'(paused[1]), 32'd0);

        // R10: strobe with prescale write is not counted
        load(2, 1); set_pre(2);
        line_stb = 1'b1; pre_val = 8'd2; pre_wr = 1'b1; step("R10 strobe+write");
        run_clear(2, n); check("R10 strobe ignored", n, 3);

        // random phase
        void'($urandom(32'd4242));
        ch_en = '1;
        for (int k = 0; k < 4000; k++) begin
            line_stb = ($urandom % 100) < 60;
            if (($urandom % 100) < 2) begin pre_wr = 1'b1; pre_val = PW'($urandom % 4); end
            for (int c = 0; c < NCH; c++) begin
                if (($urandom % 100) < 3) begin
                    pause_ld[c] = 1'b1;
                    pause_val[c*CW +: CW] = CW'($urandom % 12);
                end
                if (($urandom % 100) < 4) ch_en[c] = ~ch_en[c];
                addr_wr[c] = ($urandom % 100) < 10;
            end
            step("R9 random mix");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule